// File: doc/BRIEF.md
# Vector Fused Multiply-Add Operand Router with Masked Writeback

This block sits between a vector register file and a row of per-lane fused multiply-add units working on 32-bit elements. Each operation supplies three vectors. The first is the destination vector, which is also the first source. The second is a register source. The third comes either from a register or from memory. A form selector picks which of the three operands are multiplied and which one is added. The block routes them to every lane's multiplier and addend inputs. It can replicate one 32-bit memory element across all lanes, and it chooses between a global rounding mode and a rounding mode supplied with the operation.

On the way back, the block builds the new destination vector. Lanes that are enabled take the lane result. Masked-off lanes either keep their old value or are cleared, depending on the mask mode. Every bit at or above the active vector length is forced to zero. Exception flags from the enabled lanes are ORed into one 5-bit word.

The per-lane arithmetic is a replaceable lane primitive. The version delivered here is an integer stand-in with a fully defined result and flag behaviour, so routing, masking and rounding selection can all be observed at the ports. Results and flags are registered and appear one cycle after the request.

Top module: `vfma_route_wb`

## Requirements
- R1: A request with `in_valid` high produces `out_valid` high on the next clock edge, with `out_vec` and `out_flags` updated on that same edge. Synchronous reset clears `out_valid`, `out_vec` and `out_flags`.
- R2: Form code 0 computes dst*src3 + src2 in each lane.
- R3: Form code 1 computes src2*dst + src3 in each lane.
- R4: Form code 2 computes src2*src3 + dst in each lane. Form code 3 behaves as code 2.
- R5: Vector-length code 0 activates 4 lanes (128 bits), code 1 activates 8 lanes (256 bits), and codes 2 and 3 activate 16 lanes (512 bits), capped at the lane count. Every output bit of an inactive lane is zero.
- R6: When `in_mask_en` is low, every active lane receives its new lane result.
- R7: When masking is enabled and `in_zero_mode` is low, an active lane whose mask bit is 0 keeps its `in_dst` value.
- R8: When masking is enabled and `in_zero_mode` is high, an active lane whose mask bit is 0 becomes zero.
- R9: Mask bits at or above the active lane count have no effect on the output vector or the flags.
- R10: When `in_src3_mem` and `in_bcast` are both high, bits [31:0] of `in_src3` replace the third source in every lane. With a register source, `in_bcast` does not replicate anything.
- R11: The per-operation rounding mode `in_rm_op` is used only when the third source is a register, the length code is 2 or 3 and `in_bcast` is high. In every other case `in_rm_glb` is used.
- R12: `out_flags` is the OR of the flags of active lanes with an enabled mask bit. Other lanes contribute nothing.
- R13: The stand-in lane forms the 64-bit sum m*n + a. Its result is the low 32 bits XOR the 2-bit rounding code placed in bits [1:0]. Flag bit 0 is set when the upper 32 bits of the sum are nonzero, flag bit 1 is set when the result is zero, and flag bits [4:2] are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_form | input | 2 | Operand form: 0, 1, or 2/3 |
| in_vlen | input | 2 | Vector-length code |
| in_dst | input | 512 | Destination / first source vector |
| in_src2 | input | 512 | Second source vector |
| in_src3 | input | 512 | Third source vector or memory value |
| in_src3_mem | input | 1 | Third source comes from memory |
| in_bcast | input | 1 | Broadcast / rounding-override bit |
| in_mask_en | input | 1 | Masking enabled |
| in_mask | input | 16 | Per-lane write mask |
| in_zero_mode | input | 1 | 1 = zeroing, 0 = merging |
| in_rm_glb | input | 2 | Global rounding mode |
| in_rm_op | input | 2 | Per-operation rounding mode |
| out_valid | output | 1 | Result valid |
| out_vec | output | 512 | New destination vector |
| out_flags | output | 5 | ORed lane exception flags |

## Verification
Per-lane masking and length truncation act on the same output word in the same cycle. The hardest overlap is a 128-bit or 256-bit merge-masked request whose mask also has bits set above the active count. Here the upper lanes must be zero, must not merge old data and must raise no flags, while the masked-off lanes below the limit keep their old values. The bench issues such requests together with memory broadcast, and compares every lane and the flag word against a model built from the requirements.

// File: rtl/vfma_pkg.sv
package vfma_pkg;

    localparam int unsigned ELEM_W = 32;
    localparam int unsigned FLAG_W = 5;

    typedef enum logic [1:0] {
        FORM_DM3A2 = 2'd0,
        FORM_2MDA3 = 2'd1,
        FORM_23AD  = 2'd2,
        FORM_ALT   = 2'd3
    } form_e;

    typedef struct packed {
        logic [ELEM_W-1:0] mul_l;
        logic [ELEM_W-1:0] mul_r;
        logic [ELEM_W-1:0] add;
    } lane_ops_t;

    typedef struct packed {
        logic [ELEM_W-1:0] value;
        logic [FLAG_W-1:0] flags;
    } lane_res_t;

    function automatic int unsigned active_lanes(input logic [1:0] vlen_code,
                                                 input int unsigned max_lanes);
        int unsigned n;
        case (vlen_code)
            2'd0:    n = 4;
            2'd1:    n = 8;
            default: n = 16;
        endcase
        if (n > max_lanes) n = max_lanes;
        return n;
    endfunction

endpackage

// File: rtl/vfma_operand_router.sv
module vfma_operand_router
    import vfma_pkg::*;
#(
    parameter int unsigned LANES = 16
) (
    input  logic [1:0]              form,
    input  logic [1:0]              vlen,
    input  logic [LANES*ELEM_W-1:0] dst,
    input  logic [LANES*ELEM_W-1:0] src2,
    input  logic [LANES*ELEM_W-1:0] src3,
    input  logic                    src3_mem,
    input  logic                    bcast,
    input  logic [1:0]              rm_glb,
    input  logic [1:0]              rm_op,
    output lane_ops_t [LANES-1:0]   ops,
    output logic [1:0]              rm_sel
);
    logic use_bcast;
    logic use_rm_op;

    assign use_bcast = src3_mem & bcast;
    assign use_rm_op = ~src3_mem & bcast & (vlen[1] == 1'b1);
    assign rm_sel    = use_rm_op ? rm_op : rm_glb;

    for (genvar i = 0; i < LANES; i++) begin : g_route
        logic [ELEM_W-1:0] d_e, s2_e, s3_e;
        assign d_e  = dst[i*ELEM_W +: ELEM_W];
        assign s2_e = src2[i*ELEM_W +: ELEM_W];
        assign s3_e = use_bcast ? src3[ELEM_W-1:0] : src3[i*ELEM_W +: ELEM_W];

        always_comb begin
            case (form_e'(form))
                FORM_DM3A2: ops[i] = '{mul_l: d_e,  mul_r: s3_e, add: s2_e};
                FORM_2MDA3: ops[i] = '{mul_l: s2_e, mul_r: d_e,  add: s3_e};
                default:    ops[i] = '{mul_l: s2_e, mul_r: s3_e, add: d_e};
            endcase
        end
    end
endmodule

// File: rtl/vfma_lane_stub.sv
module vfma_lane_stub
    import vfma_pkg::*;
(
    input  lane_ops_t   ops,
    input  logic [1:0]  rm,
    output lane_res_t   res
);
    logic [2*ELEM_W-1:0] full;
    logic [ELEM_W-1:0]   rounded;

    always_comb begin
        full    = (2*ELEM_W)'(ops.mul_l) * (2*ELEM_W)'(ops.mul_r)
                + (2*ELEM_W)'(ops.add);
        rounded = full[ELEM_W-1:0] ^ {{(ELEM_W-2){1'b0}}, rm};
        res.value = rounded;
        res.flags = {3'b000, (rounded == '0), (|full[2*ELEM_W-1:ELEM_W])};
    end
endmodule

// File: rtl/vfma_writeback.sv
module vfma_writeback
    import vfma_pkg::*;
#(
    parameter int unsigned LANES = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [1:0]              vlen,
    input  logic                    mask_en,
    input  logic [LANES-1:0]        mask,
    input  logic                    zero_mode,
    input  logic [LANES*ELEM_W-1:0] dst,
    input  lane_res_t [LANES-1:0]   res,
    output logic                    out_valid,
    output logic [LANES*ELEM_W-1:0] out_vec,
    output logic [FLAG_W-1:0]       out_flags
);
    localparam int unsigned VW = LANES * ELEM_W;

    int unsigned               n_act;
    logic [LANES-1:0]          act, take;
    logic [VW-1:0]             vec_d;
    logic [FLAG_W-1:0]         flags_d;

    assign n_act = active_lanes(vlen, LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign act[i]  = (i < n_act);
        assign take[i] = act[i] & (~mask_en | mask[i]);
        always_comb begin
            if (!act[i])       vec_d[i*ELEM_W +: ELEM_W] = '0;
            else if (take[i])  vec_d[i*ELEM_W +: ELEM_W] = res[i].value;
            else if (zero_mode) vec_d[i*ELEM_W +: ELEM_W] = '0;
            else               vec_d[i*ELEM_W +: ELEM_W] = dst[i*ELEM_W +: ELEM_W];
        end

        assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (i >= active_lanes(vlen, LANES)))
                |=> (out_vec[i*ELEM_W +: ELEM_W] == '0));

        assert_merge_keep_R7: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (i < active_lanes(vlen, LANES)) && mask_en && !mask[i] && !zero_mode)
                |=> (out_vec[i*ELEM_W +: ELEM_W] == $past(dst[i*ELEM_W +: ELEM_W])));

        assert_zero_kill_R8: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mask_en && !mask[i] && zero_mode)
                |=> (out_vec[i*ELEM_W +: ELEM_W] == '0));
    end

    always_comb begin
        flags_d = '0;
        for (int i = 0; i < LANES; i++) begin
            if (take[i]) flags_d = flags_d | res[i].flags;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
            out_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec   <= vec_d;
                out_flags <= flags_d;
            end
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_flags_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && (mask == '0)) |=> (out_flags == '0));
endmodule

// File: rtl/vfma_route_wb.sv
module vfma_route_wb
    import vfma_pkg::*;
#(
    parameter int unsigned LANES = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [1:0]              in_form,
    input  logic [1:0]              in_vlen,
    input  logic [LANES*32-1:0]     in_dst,
    input  logic [LANES*32-1:0]     in_src2,
    input  logic [LANES*32-1:0]     in_src3,
    input  logic                    in_src3_mem,
    input  logic                    in_bcast,
    input  logic                    in_mask_en,
    input  logic [LANES-1:0]        in_mask,
    input  logic                    in_zero_mode,
    input  logic [1:0]              in_rm_glb,
    input  logic [1:0]              in_rm_op,
    output logic                    out_valid,
    output logic [LANES*32-1:0]     out_vec,
    output logic [4:0]              out_flags
);
    lane_ops_t [LANES-1:0] ops;
    lane_res_t [LANES-1:0] res;
    logic [1:0]            rm_sel;

    vfma_operand_router #(.LANES(LANES)) u_router (
        .form     (in_form),
        .vlen     (in_vlen),
        .dst      (in_dst),
        .src2     (in_src2),
        .src3     (in_src3),
        .src3_mem (in_src3_mem),
        .bcast    (in_bcast),
        .rm_glb   (in_rm_glb),
        .rm_op    (in_rm_op),
        .ops      (ops),
        .rm_sel   (rm_sel)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_unit
        vfma_lane_stub u_lane (
            .ops (ops[i]),
            .rm  (rm_sel),
            .res (res[i])
        );
    end

    vfma_writeback #(.LANES(LANES)) u_wb (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .vlen      (in_vlen),
        .mask_en   (in_mask_en),
        .mask      (in_mask),
        .zero_mode (in_zero_mode),
        .dst       (in_dst),
        .res       (res),
        .out_valid (out_valid),
        .out_vec   (out_vec),
        .out_flags (out_flags)
    );

    assert_rm_pick_R11: assert property (@(posedge clk) disable iff (rst)
        (in_src3_mem || !in_bcast || !in_vlen[1]) |-> (rm_sel == in_rm_glb));
endmodule

// File: tb/test_vfma_route_wb.sv
module test_vfma_route_wb;
    localparam int L = 16;
    localparam int W = L * 32;

    logic clk = 0, rst = 1;
    logic in_valid = 0;
    logic [1:0] in_form = 0, in_vlen = 0, in_rm_glb = 0, in_rm_op = 0;
    logic [W-1:0] in_dst = '0, in_src2 = '0, in_src3 = '0;
    logic in_src3_mem = 0, in_bcast = 0, in_mask_en = 0, in_zero_mode = 0;
    logic [L-1:0] in_mask = '0;
    logic out_valid;
    logic [W-1:0] out_vec;
    logic [4:0] out_flags;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vfma_route_wb #(.LANES(L)) i_vfma_route_wb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_form(in_form),
        .in_vlen(in_vlen), .in_dst(in_dst), .in_src2(in_src2), .in_src3(in_src3),
        .in_src3_mem(in_src3_mem), .in_bcast(in_bcast), .in_mask_en(in_mask_en),
        .in_mask(in_mask), .in_zero_mode(in_zero_mode), .in_rm_glb(in_rm_glb),
        .in_rm_op(in_rm_op), .out_valid(out_valid), .out_vec(out_vec),
        .out_flags(out_flags)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected vector and flags derived from the requirement text
    task automatic model(output logic [W-1:0] ev, output logic [4:0] ef);
        int n;
        logic [1:0] rm;
        n = (in_vlen == 0) ? 4 : (in_vlen == 1) ? 8 : 16;
        rm = (!in_src3_mem && in_bcast && in_vlen >= 2) ? in_rm_op : in_rm_glb; // R11
        ev = '0; ef = '0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] d, s2, s3, m, r, a, val;
            logic [63:0] full;
            d  = in_dst[i*32 +: 32];
            s2 = in_src2[i*32 +: 32];
            s3 = (in_src3_mem && in_bcast) ? in_src3[31:0] : in_src3[i*32 +: 32];
            case (in_form)
                2'd0: begin m = d;  r = s3; a = s2; end
                2'd1: begin m = s2; r = d;  a = s3; end
                default: begin m = s2; r = s3; a = d; end
            endcase
            full = {32'b0, m} * {32'b0, r} + {32'b0, a};
            val  = full[31:0] ^ {30'b0, rm};
            if (!in_mask_en || in_mask[i]) begin
                ev[i*32 +: 32] = val;
                ef = ef | {3'b0, (val == 0), (full[63:32] != 0)};
            end else if (!in_zero_mode) begin
                ev[i*32 +: 32] = d;
            end
        end
    endtask

    task automatic run_op(input string req);
        logic [W-1:0] ev;
        logic [4:0] ef;
        model(ev, ef);
        in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        check(out_valid === 1'b1, {req, " valid"}, W'(out_valid), W'(1));
        check(out_vec === ev, {req, " vector"}, out_vec, ev);
        check(out_flags === ef, {req, " flags"}, W'(out_flags), W'(ef));
    endtask

    task automatic set_op(input logic [1:0] f, input logic [1:0] vl, input bit mem,
                          input bit bc, input bit men, input logic [L-1:0] mk,
                          input bit zm, input logic [1:0] rg, input logic [1:0] ro);
        in_form = f; in_vlen = vl; in_src3_mem = mem; in_bcast = bc;
        in_mask_en = men; in_mask = mk; in_zero_mode = zm;
        in_rm_glb = rg; in_rm_op = ro;
    endtask

    task automatic t_reset();
        check(out_valid === 1'b0, "R1 reset valid", W'(out_valid), W'(0));
        check(out_vec === '0, "R1 reset vector", out_vec, '0);
        check(out_flags === '0, "R1 reset flags", W'(out_flags), W'(0));
    endtask

    task automatic t_forms();
        set_op(2'd0, 2'd2, 0, 0, 0, '0, 0, 2'd0, 2'd0); run_op("R2 form0");
        set_op(2'd1, 2'd2, 0, 0, 0, '0, 0, 2'd1, 2'd2); run_op("R3 form1");
        set_op(2'd2, 2'd2, 0, 0, 0, '0, 0, 2'd0, 2'd0); run_op("R4 form2");
        set_op(2'd3, 2'd2, 0, 0, 0, '0, 0, 2'd0, 2'd0); run_op("R4 form3");
    endtask

    task automatic t_lengths();
        set_op(2'd0, 2'd0, 0, 0, 0, '0, 0, 2'd0, 2'd0); run_op("R5 len128 R6");
        set_op(2'd1, 2'd1, 0, 0, 0, '0, 0, 2'd3, 2'd0); run_op("R5 len256");
        set_op(2'd2, 2'd3, 0, 0, 0, '0, 0, 2'd0, 2'd0); run_op("R5 len code3");
    endtask

    task automatic t_masks();
        set_op(2'd0, 2'd2, 0, 0, 1, 16'hA5C3, 0, 2'd0, 2'd0); run_op("R7 merge");
        set_op(2'd1, 2'd2, 0, 0, 1, 16'h3C96, 1, 2'd0, 2'd0); run_op("R8 zero");
        set_op(2'd2, 2'd2, 0, 0, 1, 16'h0000, 0, 2'd0, 2'd0); run_op("R12 no lanes");
        // upper mask bits set, lower all clear: merge, no flags, upper lanes zero
        set_op(2'd0, 2'd0, 0, 0, 1, 16'hFFF0, 0, 2'd0, 2'd0); run_op("R9 R12 upper mask");
        set_op(2'd2, 2'd1, 0, 0, 1, 16'hFF05, 1, 2'd0, 2'd0); run_op("R9 zero len256");
    endtask

    task automatic t_bcast_rm();
        set_op(2'd0, 2'd2, 1, 1, 0, '0, 0, 2'd1, 2'd2); run_op("R10 bcast form0");
        set_op(2'd1, 2'd2, 1, 1, 0, '0, 0, 2'd0, 2'd3); run_op("R10 bcast form1");
        set_op(2'd2, 2'd2, 0, 1, 0, '0, 0, 2'd1, 2'd2); run_op("R10 R11 reg override");
        set_op(2'd2, 2'd1, 0, 1, 0, '0, 0, 2'd1, 2'd2); run_op("R11 len256 global");
        set_op(2'd0, 2'd2, 1, 0, 0, '0, 0, 2'd2, 2'd1); run_op("R11 mem global");
    endtask

    task automatic t_combined();
        set_op(2'd2, 2'd1, 1, 1, 1, 16'hF0A6, 0, 2'd2, 2'd1); run_op("R7 R9 R10 combined");
        set_op(2'd0, 2'd0, 1, 1, 1, 16'hFF0A, 1, 2'd3, 2'd0); run_op("R8 R13 combined");
    endtask

    task automatic t_hold();
        logic [W-1:0] prev;
        prev = out_vec;
        in_dst = ~in_dst;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 idle valid", W'(out_valid), W'(0));
        check(out_vec === prev, "R1 idle hold", out_vec, prev);
        in_dst = ~in_dst;
    endtask

    initial begin
        for (int i = 0; i < L; i++) begin
            in_dst[i*32 +: 32]  = (i % 3 == 0) ? 32'h4000_0000 + i : 32'h0000_0100 + 7 * i;
            in_src2[i*32 +: 32] = 32'h0000_0003 + 11 * i;
            in_src3[i*32 +: 32] = 32'h0000_0020 + 5 * i;
        end
        // lane 1 products to zero: dst1*0 + 0 under form0 with rm 0 -> zero flag (R13)
        in_src3[32 +: 32] = 32'h0;
        in_src2[32 +: 32] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_forms();
        t_lengths();
        t_masks();
        t_bcast_rm();
        t_combined();
        t_hold();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule